// File: doc/BRIEF.md
# Instruction-Bus Loop Injector

This block watches a processor's local instruction-fetch bus, which has a fixed one-cycle fetch latency. It compares each fetch address against a small table of hot-loop start addresses. When a fetch hits a valid entry, the block replaces the memory word returned to the processor with a generated two-word absolute branch. The first word, an immediate prefix, answers the matching fetch. The second word, the branch itself, answers the next fetch. Together they send the processor to the communication routine that the entry names. Replies keep exactly the timing of the memory, so the processor cannot tell an injected word from a fetched one.

When a hit occurs, the block also streams the entry's accelerator configuration out of a configuration store that is computed in the block. The stream runs on a ready/valid link and overlaps with the routine that sends the operands. It is skipped when the accelerator already holds that configuration. The scheme works only if every fetch travels over the monitored bus, so no instruction cache may sit between the processor and the injector. An enable input turns the block into a plain wire.

Top module: `loop_injector`

## Requirements
- R1: After reset, every table entry is invalid, fetches return the memory word, and no configuration counts as loaded (the first hit always streams).
- R2: A fetch whose address matches no valid entry returns the memory word `mem_rdata` on `cpu_rdata` in the cycle after the request.
- R3: A fetch whose address equals the start address of a valid entry returns the prefix word `{16'hB000, target[31:16]}` in the cycle after the request.
- R4: The next fetch request after a prefix returns the branch word `{16'hB808, target[15:0]}`, whatever its address. That fetch does not start a new match.
- R5: When several valid entries match the same address, the entry with the lowest index is used.
- R6: While `en` is low, every fetch returns the memory word and no stream starts. A branch word still pending from an earlier prefix is discarded.
- R7: A hit whose configuration index differs from the last streamed one sends `CFG_WORDS` words in order. Word j of configuration c is `{8'hC5, c[7:0], j[15:0]}`, and `cs_last` is high on the final word.
- R8: While `cs_valid` is high and `cs_ready` is low, `cs_valid` and `cs_data` stay unchanged.
- R9: A hit whose configuration index equals the last streamed one starts no stream.
- R10: A hit that arrives while a stream is in progress neither restarts nor alters that stream.
- R11: Writing an entry through the table port changes matching from the next fetch onward. Entries written as invalid never match.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Injection enable |
| if_req | input | 1 | Fetch request strobe from the processor |
| if_addr | input | 32 | Fetch address |
| mem_rdata | input | 32 | Word from instruction memory, one cycle after the request |
| cpu_rdata | output | 32 | Word returned to the processor |
| tbl_we | input | 1 | Table entry write strobe |
| tbl_idx | input | 3 | Entry index to write |
| tbl_valid | input | 1 | Valid flag for the written entry |
| tbl_start | input | 32 | Loop start address for the written entry |
| tbl_target | input | 32 | Routine target address for the written entry |
| tbl_cfg | input | 8 | Configuration index for the written entry |
| cs_data | output | 32 | Configuration stream word |
| cs_valid | output | 1 | Configuration stream word valid |
| cs_last | output | 1 | Final word of a configuration |
| cs_ready | input | 1 | Accelerator accepts the stream word |

## Verification
The assertions assume that `mem_rdata` is valid only in the cycle after a request, and that the processor asks for the branch word with the next request after a prefix and never pauses `en` in between unless it means to discard the pending branch. The stimulus issues one fetch at a time and changes `en` only between fetches. It writes table entries only while no fetch is in flight, and it holds `cs_ready` low until it is ready to drain a whole configuration. That lets a hit arrive during an active stream while the stream holds still.

// File: rtl/lpinj_pkg.sv
package lpinj_pkg;
    localparam int ADDR_W = 32;
    localparam int DATA_W = 32;
    localparam int CFG_W  = 8;

    localparam logic [15:0] PREFIX_OP = 16'hB000;
    localparam logic [15:0] BRANCH_OP = 16'hB808;
    localparam logic [7:0]  CFG_TAG   = 8'hC5;

    typedef enum logic [1:0] {
        RSP_MEM    = 2'd0,
        RSP_PREFIX = 2'd1,
        RSP_BRANCH = 2'd2
    } rsp_sel_e;

    typedef struct packed {
        logic              valid;
        logic [ADDR_W-1:0] start;
        logic [ADDR_W-1:0] target;
        logic [CFG_W-1:0]  cfg;
    } loop_ent_t;

    typedef struct packed {
        logic              hit;
        logic [ADDR_W-1:0] target;
        logic [CFG_W-1:0]  cfg;
    } hit_t;

    function automatic logic [DATA_W-1:0] prefix_word(input logic [ADDR_W-1:0] t);
        return {PREFIX_OP, t[31:16]};
    endfunction

    function automatic logic [DATA_W-1:0] branch_word(input logic [ADDR_W-1:0] t);
        return {BRANCH_OP, t[15:0]};
    endfunction

    function automatic logic [DATA_W-1:0] cfg_word(input logic [CFG_W-1:0] c,
                                                   input logic [15:0] j);
        return {CFG_TAG, c, j};
    endfunction
endpackage

// File: rtl/lpinj_match.sv
module lpinj_match
    import lpinj_pkg::*;
#(
    parameter int ENTRIES = 8,
    localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  loop_ent_t         wr_ent,
    input  logic [ADDR_W-1:0] addr,
    output hit_t              result
);
    loop_ent_t          table_q [ENTRIES];
    logic [ENTRIES-1:0] match;
    logic [ENTRIES-1:0] grant;

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < ENTRIES; i++) table_q[i] <= '0;
        end else if (wr_en) begin
            table_q[wr_idx] <= wr_ent;
        end
    end

    for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
        assign match[g] = table_q[g].valid && (table_q[g].start == addr);
        if (g == 0) begin : g_first
            assign grant[g] = match[g];
        end else begin : g_rest
            assign grant[g] = match[g] && !(|match[g-1:0]);
        end
    end

    always_comb begin
        result = '0;
        for (int i = 0; i < ENTRIES; i++) begin
            if (grant[i]) begin
                result.hit    = 1'b1;
                result.target = result.target | table_q[i].target;
                result.cfg    = result.cfg | table_q[i].cfg;
            end
        end
    end

    // R5: at most one entry is ever selected
    a_r5_single_grant: assert property (@(posedge clk) disable iff (rst)
        $onehot0(grant));
endmodule

// File: rtl/lpinj_fetch.sv
module lpinj_fetch
    import lpinj_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              en,
    input  logic              req,
    input  hit_t              hit,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic [DATA_W-1:0] rdata,
    output logic              trig
);
    rsp_sel_e          sel_q;
    logic              pend_q;
    logic [ADDR_W-1:0] tgt_q;

    assign trig = req && en && !pend_q && hit.hit;

    always_ff @(posedge clk) begin
        if (rst) begin
            sel_q  <= RSP_MEM;
            pend_q <= 1'b0;
            tgt_q  <= '0;
        end else if (!en) begin
            sel_q  <= RSP_MEM;
            pend_q <= 1'b0;
        end else if (req) begin
            if (pend_q) begin
                sel_q  <= RSP_BRANCH;
                pend_q <= 1'b0;
            end else if (hit.hit) begin
                sel_q  <= RSP_PREFIX;
                pend_q <= 1'b1;
                tgt_q  <= hit.target;
            end else begin
                sel_q  <= RSP_MEM;
            end
        end else begin
            sel_q <= RSP_MEM;
        end
    end

    always_comb begin
        unique case (sel_q)
            RSP_PREFIX: rdata = prefix_word(tgt_q);
            RSP_BRANCH: rdata = branch_word(tgt_q);
            default:    rdata = mem_rdata;
        endcase
    end

    // R3: a hit returns a prefix word on the following cycle
    a_r3_prefix_after_hit: assert property (@(posedge clk) disable iff (rst)
        trig |=> rdata[31:16] == PREFIX_OP);
    // R4: the request after a prefix gets the branch opcode
    a_r4_branch_follows: assert property (@(posedge clk) disable iff (rst)
        (sel_q == RSP_PREFIX) && req && en |=> rdata[31:16] == BRANCH_OP);
endmodule

// File: rtl/lpinj_cfg_stream.sv
module lpinj_cfg_stream
    import lpinj_pkg::*;
#(
    parameter int CFG_WORDS = 4,
    localparam int IDX_W    = (CFG_WORDS > 1) ? $clog2(CFG_WORDS) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              trig,
    input  logic [CFG_W-1:0]  trig_cfg,
    output logic [DATA_W-1:0] data,
    output logic              valid,
    output logic              last,
    input  logic              ready
);
    logic             busy_q;
    logic [IDX_W-1:0] idx_q;
    logic [CFG_W-1:0] cfg_q;
    logic             loaded_v_q;
    logic             start;

    assign start = trig && !busy_q && (!loaded_v_q || (cfg_q != trig_cfg));
    assign valid = busy_q;
    assign data  = cfg_word(cfg_q, 16'(idx_q));
    assign last  = busy_q && (idx_q == IDX_W'(CFG_WORDS - 1));

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_q     <= 1'b0;
            idx_q      <= '0;
            cfg_q      <= '0;
            loaded_v_q <= 1'b0;
        end else if (start) begin
            busy_q     <= 1'b1;
            idx_q      <= '0;
            cfg_q      <= trig_cfg;
            loaded_v_q <= 1'b1;
        end else if (busy_q && ready) begin
            if (last) begin
                busy_q <= 1'b0;
                idx_q  <= '0;
            end else begin
                idx_q <= idx_q + 1'b1;
            end
        end
    end

    // R8: a stalled word is held
    a_r8_hold_stalled: assert property (@(posedge clk) disable iff (rst)
        valid && !ready |=> valid && $stable(data));
    // R9: a hit for the already loaded configuration leaves the link idle
    a_r9_no_restream: assert property (@(posedge clk) disable iff (rst)
        trig && !busy_q && loaded_v_q && (trig_cfg == cfg_q) |=> !valid);
    // R10: an active stream keeps its configuration until it completes
    a_r10_keep_busy: assert property (@(posedge clk) disable iff (rst)
        busy_q && !(ready && last) |=> busy_q && $stable(cfg_q));
endmodule

// File: rtl/loop_injector.sv
module loop_injector
    import lpinj_pkg::*;
#(
    parameter int ENTRIES   = 8,
    parameter int CFG_WORDS = 4,
    localparam int TIDX_W   = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               en,
    input  logic               if_req,
    input  logic [ADDR_W-1:0]  if_addr,
    input  logic [DATA_W-1:0]  mem_rdata,
    output logic [DATA_W-1:0]  cpu_rdata,
    input  logic               tbl_we,
    input  logic [TIDX_W-1:0]  tbl_idx,
    input  logic               tbl_valid,
    input  logic [ADDR_W-1:0]  tbl_start,
    input  logic [ADDR_W-1:0]  tbl_target,
    input  logic [CFG_W-1:0]   tbl_cfg,
    output logic [DATA_W-1:0]  cs_data,
    output logic               cs_valid,
    output logic               cs_last,
    input  logic               cs_ready
);
    loop_ent_t wr_ent;
    hit_t      hit;
    logic      trig;

    assign wr_ent = '{valid: tbl_valid, start: tbl_start,
                      target: tbl_target, cfg: tbl_cfg};

    lpinj_match #(.ENTRIES(ENTRIES)) u_match (
        .clk    (clk),
        .rst    (rst),
        .wr_en  (tbl_we),
        .wr_idx (tbl_idx),
        .wr_ent (wr_ent),
        .addr   (if_addr),
        .result (hit)
    );

    lpinj_fetch u_fetch (
        .clk       (clk),
        .rst       (rst),
        .en        (en),
        .req       (if_req),
        .hit       (hit),
        .mem_rdata (mem_rdata),
        .rdata     (cpu_rdata),
        .trig      (trig)
    );

    lpinj_cfg_stream #(.CFG_WORDS(CFG_WORDS)) u_stream (
        .clk      (clk),
        .rst      (rst),
        .trig     (trig),
        .trig_cfg (hit.cfg),
        .data     (cs_data),
        .valid    (cs_valid),
        .last     (cs_last),
        .ready    (cs_ready)
    );

    // R6: with injection disabled the memory word reaches the processor
    a_r6_passthru: assert property (@(posedge clk) disable iff (rst)
        !en && if_req |=> cpu_rdata == mem_rdata);
    // R6: no stream starts while disabled
    a_r6_no_start: assert property (@(posedge clk) disable iff (rst)
        !en && !cs_valid |=> !cs_valid);
endmodule

// File: tb/tb_loop_injector.sv
module tb_loop_injector;
    localparam int NW = 4;
    localparam logic [31:0] MEMX = 32'h1357_9BDF;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        en = 1'b1;
    logic        if_req = 1'b0;
    logic [31:0] if_addr = '0;
    logic [31:0] mem_rdata;
    logic [31:0] cpu_rdata;
    logic        tbl_we = 1'b0;
    logic [2:0]  tbl_idx = '0;
    logic        tbl_valid = 1'b0;
    logic [31:0] tbl_start = '0;
    logic [31:0] tbl_target = '0;
    logic [7:0]  tbl_cfg = '0;
    logic [31:0] cs_data;
    logic        cs_valid, cs_last;
    logic        cs_ready = 1'b0;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    always_ff @(posedge clk) if (if_req) mem_rdata <= if_addr ^ MEMX;

    loop_injector #(.ENTRIES(8), .CFG_WORDS(NW)) dut (
        .clk(clk), .rst(rst), .en(en), .if_req(if_req), .if_addr(if_addr),
        .mem_rdata(mem_rdata), .cpu_rdata(cpu_rdata), .tbl_we(tbl_we),
        .tbl_idx(tbl_idx), .tbl_valid(tbl_valid), .tbl_start(tbl_start),
        .tbl_target(tbl_target), .tbl_cfg(tbl_cfg), .cs_data(cs_data),
        .cs_valid(cs_valid), .cs_last(cs_last), .cs_ready(cs_ready)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic fetch(input string req, input logic [31:0] a, input logic [31:0] exp);
        if_req  = 1'b1;
        if_addr = a;
        @(negedge clk);
        check(req, cpu_rdata, exp);
        if_req = 1'b0;
    endtask

    task automatic wr(input int i, input logic v, input logic [31:0] s,
                      input logic [31:0] t, input logic [7:0] c);
        tbl_we = 1'b1; tbl_idx = 3'(i); tbl_valid = v;
        tbl_start = s; tbl_target = t; tbl_cfg = c;
        @(negedge clk);
        tbl_we = 1'b0;
    endtask

    task automatic collect(input string req, input logic [7:0] c);
        for (int j = 0; j < NW; j++) begin
            check(req, {31'b0, cs_valid}, 32'd1);
            check(req, cs_data, {8'hC5, c, 16'(j)});
            check(req, {31'b0, cs_last}, {31'b0, (j == NW - 1)});
            cs_ready = 1'b1;
            @(negedge clk);
        end
        cs_ready = 1'b0;
        check(req, {31'b0, cs_valid}, 32'd0);
    endtask

    // {pass-through flag, address, expected word}
    localparam logic [64:0] VEC [10] = '{
        {1'b1, 32'h0000_0040, 32'h0},
        {1'b0, 32'h0000_0100, 32'hB000_0001},
        {1'b0, 32'h0000_0104, 32'hB808_2000},
        {1'b0, 32'h0000_0200, 32'hB000_ABCD},
        {1'b0, 32'h0000_0204, 32'hB808_0040},
        {1'b1, 32'h0000_0300, 32'h0},
        {1'b0, 32'h0000_0100, 32'hB000_0001},
        {1'b0, 32'h0000_0100, 32'hB808_2000},
        {1'b1, 32'h0000_0500, 32'h0},
        {1'b1, 32'h0000_0104, 32'h0}
    };

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1: empty table, no stream
        check("R1 stream idle", {31'b0, cs_valid}, 32'd0);
        fetch("R1 empty table passthru", 32'h100, 32'h100 ^ MEMX);

        wr(0, 1'b1, 32'h100, 32'h0001_2000, 8'd1);
        wr(1, 1'b1, 32'h200, 32'hABCD_0040, 8'd2);
        wr(2, 1'b1, 32'h200, 32'h5555_6666, 8'd3);
        wr(3, 1'b0, 32'h300, 32'h0000_1111, 8'd4);

        // R2 R3 R4 R5 R11 R10: stream for cfg 1 stays stalled meanwhile
        for (int k = 0; k < 10; k++) begin
            fetch(VEC[k][64] ? "R2 R11 passthru" : "R3 R4 R5 injected",
                  VEC[k][63:32], VEC[k][64] ? (VEC[k][63:32] ^ MEMX) : VEC[k][31:0]);
        end
        collect("R7 R10 cfg1 stream", 8'd1);

        // R9: same configuration again, no stream
        fetch("R3 prefix", 32'h100, 32'hB000_0001);
        check("R9 no restream", {31'b0, cs_valid}, 32'd0);
        fetch("R4 branch", 32'h104, 32'hB808_2000);

        // R8: backpressure holds data
        fetch("R5 prefix entry1", 32'h200, 32'hB000_ABCD);
        check("R8 first word", cs_data, {8'hC5, 8'd2, 16'd0});
        @(negedge clk);
        @(negedge clk);
        check("R8 held valid", {31'b0, cs_valid}, 32'd1);
        check("R8 held data", cs_data, {8'hC5, 8'd2, 16'd0});
        fetch("R4 branch", 32'h204, 32'hB808_0040);
        collect("R7 cfg2 stream", 8'd2);

        // R6: disabled
        en = 1'b0;
        fetch("R6 disabled passthru", 32'h100, 32'h100 ^ MEMX);
        @(negedge clk);
        check("R6 no stream", {31'b0, cs_valid}, 32'd0);
        en = 1'b1;
        fetch("R3 prefix", 32'h100, 32'hB000_0001);
        en = 1'b0;
        fetch("R6 pending dropped", 32'h104, 32'h104 ^ MEMX);
        en = 1'b1;
        fetch("R6 pending gone", 32'h104, 32'h104 ^ MEMX);
        collect("R7 cfg1 restream", 8'd1);

        // R11: rewrite entry 3 as valid
        wr(3, 1'b1, 32'h300, 32'h0000_7777, 8'd2);
        fetch("R11 new entry prefix", 32'h300, 32'hB000_0000);
        fetch("R11 new entry branch", 32'h304, 32'hB808_7777);
        collect("R7 cfg2 after rewrite", 8'd2);
        wr(3, 1'b0, 32'h300, 32'h0000_7777, 8'd2);
        fetch("R11 invalidated", 32'h300, 32'h300 ^ MEMX);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule